// File: doc/BRIEF.md
# Two-Wire Slave with Upstream Button/Register Report

This block is a slave on a two-wire serial bus that answers at one fixed 7-bit device address. Through the bus an external microcontroller can write two byte registers and read one byte register. The two sets are separate: a write never changes what a read returns. The readable byte is loaded from the host side of a USB function, for example from an output report delivered over the control pipe. The microcontroller picks it up by polling.

When report generation is enabled, the block builds a three-byte report and offers it on a byte-wide valid/ready interface toward a USB interrupt endpoint. It does this whenever the microcontroller stores a register byte or any button input changes. The report holds the button state and both writable registers.

The bus pins are modelled as a sampled SCL input, a sampled SDA input and an SDA pull-low enable. Both inputs are taken through two-flop synchronisers and edge-detected on the system clock.

Top module: `twi_hid_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `DEV_ADDR` (default 7'b0111000). Bit 0 of the address byte selects read (1) or write (0). Any other address is not acknowledged, and the rest of that transaction stores nothing.
- R2: In a write, the first data byte is a register pointer, and only its bit 0 counts (0 = even register, 1 = odd register). The next data byte is stored in the selected register. Each byte after that goes to the other register in turn. Every data byte is acknowledged.
- R3: In a read, every byte is the readable register, sent MSB first. Reading continues while the master acknowledges. After a master NACK, SDA stays released until the next START.
- R4: A pulse on `host_wr_i` loads `host_data_i` into the readable register. The next read returns it.
- R5: SDA is pulled low during the ninth clock of every byte the block acknowledges. The pull enable changes only while the synchronised SCL is low.
- R6: A report is three bytes in the order button state (zero-extended), even register, odd register. Each byte stays on `rpt_data_o` with `rpt_valid_o` high and unchanged until it is accepted with `rpt_ready_i`.
- R7: With `hid_en_i` high, any change of `buttons_i` produces a report that carries the new button state.
- R8: With `hid_en_i` low, register writes and button changes produce no report. Writes still update the registers.
- R9: Triggers that arrive while a report is already waiting merge into one report. That report is captured when it starts and carries the latest register contents.
- R10: After reset, SDA is released, no report is offered and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| hid_en_i | input | 1 | Enables report generation |
| buttons_i | input | BTN_W | Debounced button levels |
| host_wr_i | input | 1 | Host download strobe |
| host_data_i | input | 8 | Host download byte |
| rpt_data_o | output | 8 | Report byte to the interrupt endpoint |
| rpt_valid_o | output | 1 | Report byte is valid |
| rpt_ready_i | input | 1 | Endpoint accepts the byte |

## Verification
The assertions assume a master that follows the bus rules. SDA changes only while SCL is low, except for START and STOP. The master never starts a START or STOP while the slave is pulling SDA. Each SCL phase lasts longer than the synchroniser delay. The bench keeps to this by driving SCL with ten-clock half periods and moving SDA only in the middle of the low phase. It also holds the button inputs steady across whole transactions, so every trigger has a known place in the report sequence.

// File: rtl/twi_hid_pkg.sv
// Shared types and constants for the two-wire slave with report output.
// Assumes byte-wide bus transfers and a three-byte report.
package twi_hid_pkg;
    localparam int RPT_BYTES = 3;
    localparam int RPT_IDX_W = $clog2(RPT_BYTES);

    typedef enum logic [3:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_ADDR_END,
        BUS_ACK,
        BUS_WR,
        BUS_WR_END,
        BUS_RD,
        BUS_RD_ACK,
        BUS_SKIP
    } bus_state_t;
endpackage

// File: rtl/twi_sync_edge.sv
// Multi-stage synchroniser with rise/fall detection on the synchronised level.
// Assumes the input is asynchronous to clk; edges appear STAGES+1 cycles late.
module twi_sync_edge #(
    parameter int STAGES = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              lvl_q;

    // synchroniser chain, first stage samples the pin
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], pin_i};
    end

    // previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= RST_VAL;
        else        lvl_q <= chain[STAGES-1];
    end

    assign lvl_o  = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~lvl_q;
    assign fall_o = ~chain[STAGES-1] & lvl_q;
endmodule

// File: rtl/twi_bus_slave.sv
// Bit-level bus slave: address match, write pointer handling, read shifting.
// Assumes synchronised SCL/SDA with edge strobes; the pull enable is updated
// only on SCL falling strobes, so it changes while SCL is low.
module twi_bus_slave
    import twi_hid_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0111000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_s,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [7:0] rd_byte,
    output logic       sda_pull,
    output logic       wr_stb,
    output logic       wr_sel,
    output logic [7:0] wr_data
);
    bus_state_t state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       is_read;
    logic       first;
    logic       sel;
    logic       start_c;
    logic       stop_c;

    assign start_c = scl_s & sda_fall;
    assign stop_c  = scl_s & sda_rise;

    // protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BUS_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            is_read  <= 1'b0;
            first    <= 1'b0;
            sel      <= 1'b0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            wr_sel   <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_c) begin
                state    <= BUS_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                state    <= BUS_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    BUS_ADDR: if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        if (cnt == 4'd7) state <= BUS_ADDR_END;
                        else             cnt   <= cnt + 4'd1;
                    end
                    BUS_ADDR_END: if (scl_fall) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                            sda_pull <= 1'b1;
                            is_read  <= shreg[0];
                            first    <= 1'b1;
                            state    <= BUS_ACK;
                        end else begin
                            state <= BUS_SKIP;
                        end
                    end
                    BUS_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (is_read) begin
                            shreg    <= rd_byte;
                            sda_pull <= ~rd_byte[7];
                            state    <= BUS_RD;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= BUS_WR;
                        end
                    end
                    BUS_WR: if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        if (cnt == 4'd7) state <= BUS_WR_END;
                        else             cnt   <= cnt + 4'd1;
                    end
                    BUS_WR_END: if (scl_fall) begin
                        sda_pull <= 1'b1;
                        state    <= BUS_ACK;
                        if (first) begin
                            sel   <= shreg[0];
                            first <= 1'b0;
                        end else begin
                            wr_stb  <= 1'b1;
                            wr_sel  <= sel;
                            wr_data <= shreg;
                            sel     <= ~sel;
                        end
                    end
                    BUS_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                state    <= BUS_RD_ACK;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= ~shreg[6];
                            end
                        end
                    end
                    BUS_RD_ACK: if (scl_rise) begin
                        state <= sda_s ? BUS_SKIP : BUS_ACK;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/hid_report_tx.sv
// Report builder: merges triggers into one pending flag, captures the three
// report bytes when a report starts, and streams them on valid/ready.
// Assumes the trigger arrives no earlier than the register update it reports.
module hid_report_tx
    import twi_hid_pkg::*;
#(
    parameter int BTN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hid_en,
    input  logic             trig,
    input  logic [BTN_W-1:0] btn,
    input  logic [7:0]       reg_even,
    input  logic [7:0]       reg_odd,
    output logic [7:0]       data_o,
    output logic             valid_o,
    input  logic             ready_i
);
    logic [7:0]           snap [RPT_BYTES];
    logic [RPT_IDX_W-1:0] idx;
    logic                 pending;
    logic                 busy;

    // pending flag, capture at start, byte stepping on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            busy    <= 1'b0;
            idx     <= '0;
            for (int i = 0; i < RPT_BYTES; i++) snap[i] <= '0;
        end else begin
            if (busy) begin
                if (ready_i) begin
                    if (idx == RPT_IDX_W'(RPT_BYTES - 1)) busy <= 1'b0;
                    else                                  idx  <= idx + 1'b1;
                end
            end else if (pending && hid_en) begin
                snap[0] <= 8'(btn);
                snap[1] <= reg_even;
                snap[2] <= reg_odd;
                idx     <= '0;
                busy    <= 1'b1;
            end
            if (!hid_en)             pending <= 1'b0;
            else if (trig)           pending <= 1'b1;
            else if (!busy && pending) pending <= 1'b0;
        end
    end

    assign data_o  = snap[idx];
    assign valid_o = busy;
endmodule

// File: rtl/twi_hid_slave.sv
// Top: two-wire slave with two write registers, one host-loaded read register
// and an upstream three-byte report. Assumes debounced, clk-synchronous buttons.
module twi_hid_slave
    import twi_hid_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'b0111000,
    parameter int         BTN_W      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             hid_en_i,
    input  logic [BTN_W-1:0] buttons_i,
    input  logic             host_wr_i,
    input  logic [7:0]       host_data_i,
    output logic [7:0]       rpt_data_o,
    output logic             rpt_valid_o,
    input  logic             rpt_ready_i
);
    logic             scl_s, scl_rise, scl_fall;
    logic             sda_s, sda_rise, sda_fall;
    logic             wr_stb, wr_sel;
    logic [7:0]       wr_data;
    logic [7:0]       reg_even, reg_odd, rd_reg;
    logic [BTN_W-1:0] btn_q;
    logic             trig;

    twi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_scl_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
        .lvl_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    twi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sda_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
        .lvl_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    twi_bus_slave #(.DEV_ADDR(DEV_ADDR)) i_bus (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .rd_byte(rd_reg), .sda_pull(sda_pull_o),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    // writable registers updated by bus writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_even <= '0;
            reg_odd  <= '0;
        end else if (wr_stb) begin
            if (wr_sel) reg_odd  <= wr_data;
            else        reg_even <= wr_data;
        end
    end

    // readable register loaded by host download
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_reg <= '0;
        else if (host_wr_i) rd_reg <= host_data_i;
    end

    // previous button levels for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) btn_q <= '0;
        else        btn_q <= buttons_i;
    end

    assign trig = wr_stb | (btn_q != buttons_i);

    hid_report_tx #(.BTN_W(BTN_W)) i_rpt (
        .clk(clk), .rst_n(rst_n), .hid_en(hid_en_i), .trig(trig),
        .btn(buttons_i), .reg_even(reg_even), .reg_odd(reg_odd),
        .data_o(rpt_data_o), .valid_o(rpt_valid_o), .ready_i(rpt_ready_i)
    );
endmodule

// File: rtl/twi_hid_checker.sv
// Protocol checker for twi_hid_slave, attached with bind.
// Assumes a bus master that never drives START/STOP while the slave pulls SDA.
module twi_hid_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_pull_o,
    input logic       hid_en_i,
    input logic [7:0] rpt_data_o,
    input logic       rpt_valid_o,
    input logic       rpt_ready_i
);
    AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);                                 // R5
    AST_RELEASE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_s);                                 // R5
    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_o && !rpt_ready_i |=> rpt_valid_o);                  // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_o && !rpt_ready_i |=> $stable(rpt_data_o));          // R6
    AST_NO_REPORT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rpt_valid_o) |-> $past(hid_en_i));                       // R8
endmodule

bind twi_hid_slave twi_hid_checker i_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
    .hid_en_i(hid_en_i), .rpt_data_o(rpt_data_o),
    .rpt_valid_o(rpt_valid_o), .rpt_ready_i(rpt_ready_i)
);

// File: tb/test_twi_hid_slave.sv
// Bench: bit-banged bus master, host download driver and report consumer,
// with a bench-side register model.
module test_twi_hid_slave;
    localparam int H = 10;
    localparam logic [6:0] ADDR = 7'b0111000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_pull;
    logic       sda_line;
    logic       hid_en = 1'b0;
    logic [3:0] buttons = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = '0;
    logic [7:0] rpt_data;
    logic       rpt_valid;
    logic       rpt_ready = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [7:0] m_even = '0;
    logic [7:0] m_odd  = '0;

    always #2 clk = ~clk;
    assign sda_line = ~(m_low | sda_pull);

    twi_hid_slave i_twi_hid_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .hid_en_i(hid_en), .buttons_i(buttons),
        .host_wr_i(host_wr), .host_data_i(host_data),
        .rpt_data_o(rpt_data), .rpt_valid_o(rpt_valid), .rpt_ready_i(rpt_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; w(H); scl = 1'b1; w(H); m_low = 1'b1; w(H);
        scl = 1'b0; w(H/2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; w(H/2); scl = 1'b1; w(H); m_low = 1'b0; w(H);
    endtask

    task automatic bit_out(input logic b);
        m_low = ~b; w(H/2); scl = 1'b1; w(H); scl = 1'b0; w(H/2);
    endtask

    task automatic bit_in(output logic b);
        m_low = 1'b0; w(H/2); scl = 1'b1; w(H/2); b = sda_line; w(H/2);
        scl = 1'b0; w(H/2);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
        bit_out(~mack);
    endtask

    task automatic host_load(input logic [7:0] v);
        host_data = v; host_wr = 1'b1; w(1); host_wr = 1'b0; w(1);
    endtask

    // bus write: pointer byte then data bytes; updates the bench model
    task automatic bus_write(input logic [7:0] ptr, input logic [7:0] d0,
                             input logic [7:0] d1, input int nd);
        logic ack;
        logic sel;
        bus_start();
        wr_byte({ADDR, 1'b0}, ack); chk("R1 addr ack", ack, 1);
        wr_byte(ptr, ack);          chk("R2 ptr ack", ack, 1);
        sel = ptr[0];
        for (int k = 0; k < nd; k++) begin
            wr_byte(k == 0 ? d0 : d1, ack);
            chk("R2 data ack", ack, 1);
            if (sel) m_odd = (k == 0 ? d0 : d1); else m_even = (k == 0 ? d0 : d1);
            sel = ~sel;
        end
        bus_stop();
    endtask

    task automatic get_report(input logic [7:0] b, input logic [7:0] e,
                              input logic [7:0] o, input string tag);
        logic [7:0] exp [3];
        int t;
        exp[0] = b; exp[1] = e; exp[2] = o;
        for (int i = 0; i < 3; i++) begin
            t = 0;
            while (!rpt_valid && t < 200) begin w(1); t++; end
            chk({tag, " valid"}, rpt_valid, 1);
            chk({tag, " R6 byte"}, rpt_data, exp[i]);
            if (i == 0) begin
                w(3);
                chk("R6 held valid", rpt_valid, 1);
                chk("R6 held data", rpt_data, exp[i]);
            end
            rpt_ready = 1'b1; w(1); rpt_ready = 1'b0;
        end
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin w(1); if (rpt_valid) seen = 1; end
        chk(tag, seen, 0);
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        logic [7:0] ptrs [4];
        logic [7:0] bad [3];
        ptrs[0] = 8'h00; ptrs[1] = 8'h01; ptrs[2] = 8'hA6; ptrs[3] = 8'h7F;
        bad[0] = 8'h72; bad[1] = 8'h30; bad[2] = 8'hF0;
        w(5); rst_n = 1'b1; w(2);
        chk("R10 pull released", sda_pull, 0);
        chk("R10 no report", rpt_valid, 0);

        // R1: foreign addresses are not acknowledged and store nothing
        hid_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            bus_start();
            wr_byte(bad[i], ack); chk("R1 foreign nack", ack, 0);
            wr_byte(8'h00, ack);
            wr_byte(8'h5A, ack);
            bus_stop();
            expect_quiet(40, "R1 no store/report");
        end

        // R2/R6: pointer sweep, two data bytes each, two reports per write
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d0, d1, e1, o1;
            d0 = 8'h11 * (i + 1) + 8'h03;
            d1 = ~d0;
            bus_write(ptrs[i], d0, d1, 1);
            e1 = m_even; o1 = m_odd;
            get_report(8'h00, e1, o1, "R2 single");
            bus_write(ptrs[i], d0, d1, 2);
            // first report captured after first data byte
            if (ptrs[i][0]) get_report(8'h00, e1, d0, "R2 first");
            else            get_report(8'h00, d0, o1, "R2 first");
            get_report(8'h00, m_even, m_odd, "R2 auto-inc");
            expect_quiet(40, "R2 two reports only");
        end

        // R9: triggers merge while a report is waiting
        bus_write(8'h00, 8'hC1, 8'h00, 1);
        begin
            logic [7:0] e1, o1;
            e1 = m_even; o1 = m_odd;
            bus_write(8'h01, 8'hC2, 8'h00, 1);
            bus_write(8'h00, 8'hC3, 8'h00, 1);
            get_report(8'h00, e1, o1, "R9 first");
            get_report(8'h00, 8'hC3, 8'hC2, "R9 merged");
            expect_quiet(40, "R9 single merged");
        end

        // R7: button press and release
        for (int b = 1; b < 16; b += 5) begin
            buttons = 4'(b); w(2);
            get_report(8'(b), m_even, m_odd, "R7 press");
            buttons = 4'h0; w(2);
            get_report(8'h00, m_even, m_odd, "R7 release");
        end

        // R8: disabled - no reports, but registers still written
        hid_en = 1'b0;
        bus_write(8'h01, 8'h9D, 8'h00, 1);
        buttons = 4'h6;
        expect_quiet(60, "R8 quiet");
        buttons = 4'h0; w(2);
        hid_en = 1'b1;
        buttons = 4'h2; w(2);
        get_report(8'h02, m_even, 8'h9D, "R8 stored while disabled");
        buttons = 4'h0; w(2);
        get_report(8'h00, m_even, m_odd, "R8 release");

        // R3/R4: host download then multi-byte read; SDA released after NACK
        for (int i = 0; i < 6; i++) begin
            logic [7:0] hv;
            hv = 8'(8'h5C * i + 8'h81);
            host_load(hv);
            bus_start();
            wr_byte({ADDR, 1'b1}, ack); chk("R1 read ack", ack, 1);
            rd_byte(1'b1, v); chk("R4 read byte", v, hv);
            rd_byte(1'b1, v); chk("R3 repeat byte", v, hv);
            rd_byte(1'b0, v); chk("R3 last byte", v, hv);
            w(4); chk("R3 released after nack", sda_pull, 0);
            bus_stop();
            chk("R5 released at idle", sda_line, 1);
        end
        expect_quiet(30, "R3 read makes no report");

        // R1: foreign read address not acknowledged, SDA stays high
        bus_start();
        wr_byte({7'b0111001, 1'b1}, ack); chk("R1 foreign read nack", ack, 0);
        rd_byte(1'b0, v); chk("R1 foreign read idle", v, 8'hFF);
        bus_stop();

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule